// File: doc/BRIEF.md
# Two-Channel Wiper Register Bank with Tap Decoder

This block holds the control registers of a two-channel digital potentiometer controller. Each channel owns one wiper register and four preset registers. A host issues single-cycle commands, each made of a channel number, a preset index, an operation code and a data byte. A command can read or write the wiper register, read or write a preset register, or copy a preset into the wiper register.

The low six bits of each wiper register are decoded into a 64-bit switch-enable vector. The vector drives the tap switches of a resistor chain with 63 segments. There is one switch at each end of the chain and one switch between every pair of neighbouring segments. Exactly one switch per channel is on at any time. The vector changes in the same cycle as the wiper register, with no in-between state.

Read results and error pulses are registered. They appear on the cycle after the command is taken.

Top module: `wiper_bank`

## Requirements
- R1: After reset every wiper and preset register is zero, each channel enables only switch 0, and `rd_valid`, `rd_data` and `cmd_err` are low.
- R2: A command with opcode 1 (write wiper) stores `cmd_wdata` into the addressed channel's wiper register. From the next cycle that channel's switch vector has only bit `cmd_wdata[5:0]` set.
- R3: Only the low six wiper bits reach the decoder. The upper bits are stored and read back, but they never change the switch vector. For example, 0xC5 selects tap 5 and 0x40 selects tap 0.
- R4: A command with opcode 3 (write preset) stores `cmd_wdata` into preset `cmd_idx` of the addressed channel. The wiper and the switch vector do not change.
- R5: Opcode 0 (read wiper) and opcode 2 (read preset `cmd_idx`) each give a one-cycle `rd_valid` pulse on the next cycle, with the register value on `rd_data`. Whenever `rd_valid` is low, `rd_data` is zero.
- R6: A command with opcode 4 (load wiper) copies preset `cmd_idx` of the addressed channel into that channel's wiper register. The preset keeps its value.
- R7: A command changes only the registers of the channel named by `cmd_chan`. The other channel's registers and switch vector stay as they were.
- R8: Opcodes 5, 6 and 7 change no register and give no read pulse. They raise `cmd_err` for exactly the next cycle.
- R9: In every cycle after reset, each channel's 64-bit slice of `sw_en` has exactly one bit set. The slice changes only on the cycle after an accepted command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_chan | input | 1 | Channel number |
| cmd_idx | input | 2 | Preset register index |
| cmd_op | input | 3 | Operation code |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read result valid, one cycle |
| rd_data | output | 8 | Read result, zero when not valid |
| cmd_err | output | 1 | Illegal-opcode pulse |
| sw_en | output | 128 | Switch enables; channel c uses bits [64c+63:64c] |

## Verification
Directed cases cover the following:
- Tap 63 and the wrap to tap 0, which separate decoding of the low six bits from decoding of the full byte.
- Values with the upper bits set (0xC5), which show that the stored byte and the decoded tap differ.
- A preset load after a preset write, which separates the copy path from the direct write path.
- Illegal opcodes, each followed by readback, which show that nothing was written.

Random commands mix all eight opcodes over both channels and every preset index. They are compared against a reference model of the bank. This shows that the channels stay independent and that the read data is taken from the right register. The one-hot property of each channel is checked on every cycle.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;

   typedef enum logic [2:0] {
      OPC_RD_WIPER   = 3'd0,
      OPC_WR_WIPER   = 3'd1,
      OPC_RD_PRESET  = 3'd2,
      OPC_WR_PRESET  = 3'd3,
      OPC_LOAD_WIPER = 3'd4
   } wb_opc_e;

   function automatic logic opc_is_legal(input logic [2:0] op);
      return (op <= 3'd4);
   endfunction

endpackage

// File: rtl/wb_cmd_decode.sv
module wb_cmd_decode
   import wiper_bank_pkg::*;
#(
   parameter int N_CHAN   = 2,
   parameter int N_PRESET = 4,
   localparam int CHAN_W  = (N_CHAN   > 1) ? $clog2(N_CHAN)   : 1,
   localparam int IDX_W   = (N_PRESET > 1) ? $clog2(N_PRESET) : 1
) (
   input  logic              cmd_valid,
   input  logic [CHAN_W-1:0] cmd_chan,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [2:0]        cmd_op,
   output logic [N_CHAN-1:0] chan_sel,
   output logic              do_wr_wiper,
   output logic              do_wr_preset,
   output logic              do_load,
   output logic              do_read,
   output logic              rd_is_wiper,
   output logic              bad_cmd
);

   logic chan_ok;
   logic idx_ok;
   logic legal;

   assign chan_ok = (32'(cmd_chan) < N_CHAN);
   assign idx_ok  = (32'(cmd_idx) < N_PRESET);

   always_comb begin
      legal = opc_is_legal(cmd_op) && chan_ok;
      if ((cmd_op == OPC_RD_PRESET) || (cmd_op == OPC_WR_PRESET) ||
          (cmd_op == OPC_LOAD_WIPER))
         legal = legal && idx_ok;
   end

   assign bad_cmd      = cmd_valid && !legal;
   assign do_wr_wiper  = cmd_valid && legal && (cmd_op == OPC_WR_WIPER);
   assign do_wr_preset = cmd_valid && legal && (cmd_op == OPC_WR_PRESET);
   assign do_load      = cmd_valid && legal && (cmd_op == OPC_LOAD_WIPER);
   assign do_read      = cmd_valid && legal &&
                         ((cmd_op == OPC_RD_WIPER) || (cmd_op == OPC_RD_PRESET));
   assign rd_is_wiper  = (cmd_op == OPC_RD_WIPER);

   for (genvar c = 0; c < N_CHAN; c++) begin : g_sel
      assign chan_sel[c] = (32'(cmd_chan) == c);
   end

endmodule

// File: rtl/wb_chan_regs.sv
module wb_chan_regs #(
   parameter int N_PRESET = 4,
   parameter int DATA_W   = 8,
   localparam int IDX_W   = (N_PRESET > 1) ? $clog2(N_PRESET) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_wiper,
   input  logic              wr_preset,
   input  logic              load,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] wiper_q,
   output logic [DATA_W-1:0] preset_rd
);

   logic [DATA_W-1:0] preset_q [N_PRESET];

   for (genvar p = 0; p < N_PRESET; p++) begin : g_preset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            preset_q[p] <= '0;
         else if (wr_preset && (32'(idx) == p))
            preset_q[p] <= wdata;
      end
   end

   assign preset_rd = preset_q[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wiper_q <= '0;
      else if (wr_wiper)
         wiper_q <= wdata;
      else if (load)
         wiper_q <= preset_rd;
   end

endmodule

// File: rtl/wb_tap_decode.sv
module wb_tap_decode #(
   parameter int TAP_BITS  = 6,
   parameter bit USE_SHIFT = 1'b1,
   localparam int TAPS     = 1 << TAP_BITS
) (
   input  logic [TAP_BITS-1:0] tap,
   output logic [TAPS-1:0]     onehot
);

   if (USE_SHIFT) begin : g_shift
      assign onehot = TAPS'(1) << tap;
   end else begin : g_cmp
      for (genvar i = 0; i < TAPS; i++) begin : g_bit
         assign onehot[i] = (tap == TAP_BITS'(i));
      end
   end

endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
   import wiper_bank_pkg::*;
#(
   parameter int N_CHAN    = 2,
   parameter int N_PRESET  = 4,
   parameter int DATA_W    = 8,
   parameter int TAP_BITS  = 6,
   parameter bit USE_SHIFT = 1'b1,
   localparam int TAPS     = 1 << TAP_BITS,
   localparam int CHAN_W   = (N_CHAN   > 1) ? $clog2(N_CHAN)   : 1,
   localparam int IDX_W    = (N_PRESET > 1) ? $clog2(N_PRESET) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_valid,
   input  logic [CHAN_W-1:0]        cmd_chan,
   input  logic [IDX_W-1:0]         cmd_idx,
   input  logic [2:0]               cmd_op,
   input  logic [DATA_W-1:0]        cmd_wdata,
   output logic                     rd_valid,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     cmd_err,
   output logic [N_CHAN*TAPS-1:0]   sw_en
);

   if (N_CHAN < 1) begin : g_bad_chan
      $error("wiper_bank: N_CHAN must be at least 1");
   end
   if (N_PRESET < 1) begin : g_bad_preset
      $error("wiper_bank: N_PRESET must be at least 1");
   end
   if (TAP_BITS < 1 || TAP_BITS > DATA_W) begin : g_bad_tap
      $error("wiper_bank: TAP_BITS must lie in 1..DATA_W");
   end

   logic [N_CHAN-1:0] chan_sel;
   logic              do_wr_wiper;
   logic              do_wr_preset;
   logic              do_load;
   logic              do_read;
   logic              rd_is_wiper;
   logic              bad_cmd;

   wb_cmd_decode #(.N_CHAN(N_CHAN), .N_PRESET(N_PRESET)) u_dec (
      .cmd_valid   (cmd_valid),
      .cmd_chan    (cmd_chan),
      .cmd_idx     (cmd_idx),
      .cmd_op      (cmd_op),
      .chan_sel    (chan_sel),
      .do_wr_wiper (do_wr_wiper),
      .do_wr_preset(do_wr_preset),
      .do_load     (do_load),
      .do_read     (do_read),
      .rd_is_wiper (rd_is_wiper),
      .bad_cmd     (bad_cmd)
   );

   logic [DATA_W-1:0] wiper_v  [N_CHAN];
   logic [DATA_W-1:0] preset_v [N_CHAN];

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
      wb_chan_regs #(.N_PRESET(N_PRESET), .DATA_W(DATA_W)) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_wiper (do_wr_wiper  && chan_sel[c]),
         .wr_preset(do_wr_preset && chan_sel[c]),
         .load     (do_load      && chan_sel[c]),
         .idx      (cmd_idx),
         .wdata    (cmd_wdata),
         .wiper_q  (wiper_v[c]),
         .preset_rd(preset_v[c])
      );

      wb_tap_decode #(.TAP_BITS(TAP_BITS), .USE_SHIFT(USE_SHIFT)) u_tap (
         .tap   (wiper_v[c][TAP_BITS-1:0]),
         .onehot(sw_en[c*TAPS +: TAPS])
      );
   end

   logic [DATA_W-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      for (int c = 0; c < N_CHAN; c++) begin
         if (chan_sel[c])
            rd_word = rd_is_wiper ? wiper_v[c] : preset_v[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         cmd_err  <= 1'b0;
      end else begin
         rd_valid <= do_read;
         rd_data  <= do_read ? rd_word : '0;
         cmd_err  <= bad_cmd;
      end
   end

endmodule

// File: rtl/wiper_bank_chk.sv
module wiper_bank_chk #(
   parameter int N_CHAN   = 2,
   parameter int N_PRESET = 4,
   parameter int DATA_W   = 8,
   parameter int TAP_BITS = 6,
   localparam int TAPS    = 1 << TAP_BITS,
   localparam int CHAN_W  = (N_CHAN   > 1) ? $clog2(N_CHAN)   : 1,
   localparam int IDX_W   = (N_PRESET > 1) ? $clog2(N_PRESET) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cmd_valid,
   input logic [CHAN_W-1:0]      cmd_chan,
   input logic [IDX_W-1:0]       cmd_idx,
   input logic [2:0]             cmd_op,
   input logic [DATA_W-1:0]      cmd_wdata,
   input logic                   rd_valid,
   input logic [DATA_W-1:0]      rd_data,
   input logic                   cmd_err,
   input logic [N_CHAN*TAPS-1:0] sw_en
);

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op > 3'd4) |=> (cmd_err && !rd_valid)); // R8

   AST_ERR_ONLY_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_valid || cmd_op <= 3'd4) |=> !cmd_err); // R8

   AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd2)) |=> rd_valid); // R5

   AST_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0)); // R5

   for (genvar c = 0; c < N_CHAN; c++) begin : g_chk
      AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(sw_en[c*TAPS +: TAPS])); // R9

      AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
         !cmd_valid |=> $stable(sw_en[c*TAPS +: TAPS])); // R9

      AST_WRITE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
         (cmd_valid && cmd_op == 3'd1 && 32'(cmd_chan) == c) |=>
            (sw_en[c*TAPS +: TAPS] == (TAPS'(1) << $past(cmd_wdata[TAP_BITS-1:0])))); // R2
   end

endmodule

bind wiper_bank wiper_bank_chk #(
   .N_CHAN  (N_CHAN),
   .N_PRESET(N_PRESET),
   .DATA_W  (DATA_W),
   .TAP_BITS(TAP_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_chan (cmd_chan),
   .cmd_idx  (cmd_idx),
   .cmd_op   (cmd_op),
   .cmd_wdata(cmd_wdata),
   .rd_valid (rd_valid),
   .rd_data  (rd_data),
   .cmd_err  (cmd_err),
   .sw_en    (sw_en)
);

// File: tb/wiper_bank_bench.sv
module wiper_bank_bench;

   localparam int NC = 2;
   localparam int NP = 4;
   localparam int TAPS = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_valid = 1'b0;
   logic [0:0]   cmd_chan = '0;
   logic [1:0]   cmd_idx = '0;
   logic [2:0]   cmd_op = '0;
   logic [7:0]   cmd_wdata = '0;
   logic         rd_valid;
   logic [7:0]   rd_data;
   logic         cmd_err;
   logic [127:0] sw_en;

   int checks = 0;
   int failures = 0;

   logic [7:0] mdl_wiper [NC];
   logic [7:0] mdl_pre   [NC][NP];

   always #5 clk = ~clk;

   wiper_bank u_wiper_bank (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chan(cmd_chan),
      .cmd_idx(cmd_idx), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd_err(cmd_err), .sw_en(sw_en)
   );

   task automatic check(input logic ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_sw();
      logic [127:0] v = '0;
      for (int c = 0; c < NC; c++)
         v[c*TAPS + int'(mdl_wiper[c][5:0])] = 1'b1;
      return v;
   endfunction

   // R9: one-hot on every cycle after reset
   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NC; c++)
            check($countones(sw_en[c*TAPS +: TAPS]) == 1, "R9 one-hot",
                  128'(sw_en[c*TAPS +: TAPS]), 128'(1));
      end
   end

   // issue one command, then compare outputs one cycle later
   task automatic do_cmd(input int ch, input int ix, input int op, input logic [7:0] d,
                         input string req);
      logic       exp_rv;
      logic [7:0] exp_rd;
      logic       exp_err;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_chan  = 1'(ch);
      cmd_idx   = 2'(ix);
      cmd_op    = 3'(op);
      cmd_wdata = d;
      exp_rv = 1'b0; exp_rd = 8'h00; exp_err = 1'b0;
      case (op)
         0: begin exp_rv = 1'b1; exp_rd = mdl_wiper[ch]; end
         1: mdl_wiper[ch] = d;
         2: begin exp_rv = 1'b1; exp_rd = mdl_pre[ch][ix]; end
         3: mdl_pre[ch][ix] = d;
         4: mdl_wiper[ch] = mdl_pre[ch][ix];
         default: exp_err = 1'b1;
      endcase
      @(negedge clk);
      cmd_valid = 1'b0;
      check(rd_valid == exp_rv, {req, " rd_valid"}, 128'(rd_valid), 128'(exp_rv));
      check(rd_data == exp_rd, {req, " rd_data"}, 128'(rd_data), 128'(exp_rd));
      check(cmd_err == exp_err, {req, " cmd_err"}, 128'(cmd_err), 128'(exp_err));
      check(sw_en == exp_sw(), {req, " sw_en"}, sw_en, exp_sw());
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < NC; c++) begin
         mdl_wiper[c] = '0;
         for (int p = 0; p < NP; p++) mdl_pre[c][p] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(sw_en == exp_sw(), "R1 reset sw_en", sw_en, exp_sw());
      check(!rd_valid && rd_data == 0 && !cmd_err, "R1 reset outputs",
            128'({rd_valid, rd_data, cmd_err}), 128'(0));
      for (int p = 0; p < NP; p++) do_cmd(1, p, 2, 8'h00, "R1 preset zero");

      // R2 / R3: direct writes and upper-bit masking
      do_cmd(0, 0, 1, 8'h3F, "R2 tap63");
      do_cmd(0, 0, 1, 8'h40, "R3 wrap tap0");
      do_cmd(0, 0, 1, 8'hC5, "R3 upper bits");
      do_cmd(0, 0, 0, 8'h00, "R3 readback C5");
      // R7: other channel untouched
      do_cmd(1, 0, 0, 8'h00, "R7 chan1 wiper");
      // R4 / R6
      do_cmd(1, 2, 3, 8'h2A, "R4 preset write");
      do_cmd(1, 2, 2, 8'h00, "R5 preset read");
      do_cmd(1, 2, 4, 8'h00, "R6 load");
      do_cmd(1, 2, 2, 8'h00, "R6 preset kept");
      do_cmd(1, 0, 0, 8'h00, "R6 wiper loaded");
      // R8: illegal opcodes change nothing
      for (int op = 5; op < 8; op++) begin
         do_cmd(0, 1, op, 8'h11, "R8 illegal");
         do_cmd(0, 0, 0, 8'h00, "R8 wiper kept");
         do_cmd(0, 1, 2, 8'h00, "R8 preset kept");
      end
      // random mix across channels, indices and opcodes
      for (int n = 0; n < 400; n++)
         do_cmd(int'($urandom % NC), int'($urandom % NP), int'($urandom % 8),
                8'($urandom), "R7 random");
      // R9: idle cycles hold the vector
      repeat (5) begin
         @(negedge clk);
         check(sw_en == exp_sw(), "R9 idle hold", sw_en, exp_sw());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule